// File: doc/BRIEF.md
# Serial Echo Loop with Stop-Bit Trimming

This block receives asynchronous serial frames on one line and sends each good byte straight back out on another. The receiver and the transmitter each hold a single byte. Both are timed from one divider that gives a tick at sixteen times the bit rate, so one bit lasts `16 * DIV` clock cycles. A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit.

The far end's clock may run slightly fast. The echo can still keep up for two reasons. First, the receiver looks for the next start edge as soon as it has sampled the middle of the stop bit. Second, when the `EARLY_START` parameter is set, the transmitter may end its own stop bit early once more than half of it has gone out and another byte is waiting. With `EARLY_START` cleared, every transmitted frame keeps its full ten bit times. That is the right choice when the receiver at the far end may be slower than this block.

Three sticky or pulsed flags report what happened: a strobe for each good byte, a flag for a byte lost because the transmit holding slot was still full, and a flag for a frame whose stop bit was low.

Top module: `uart_echo`

## Requirements
- R1: After reset, `tx_o` is high and `byte_rdy_o`, `overrun_o` and `frame_err_o` are low.
- R2: Each transmitted frame is one low start bit, 8 data bits least significant bit first, and one high stop bit. Each bit lasts 16*DIV clocks, and the data bits equal the received byte.
- R3: A falling edge on `rx_i` is accepted as a start bit only if the line is still low 8 ticks later. A low pulse shorter than half a bit produces no strobe and no echo.
- R4: Data bits are sampled at bit centres, and the receiver re-arms at the middle of the stop bit. An incoming stream about 3% faster than nominal, sent back to back, is received completely.
- R5: `byte_rdy_o` is a single-cycle pulse, given once for each frame with a high stop bit.
- R6: A frame whose stop bit is sampled low sets `frame_err_o`, which stays set until reset. It gives no `byte_rdy_o` pulse and no echo.
- R7: With EARLY_START=1, if a byte is waiting and at least 9 ticks of the stop bit have been sent, the next start bit begins at once. A stream about 3% fast is then echoed with no overrun, and some start-to-start spacings are shorter than 10 bit times.
- R8: With EARLY_START=0, consecutive transmitted start edges are at least 160 ticks apart.
- R9: A byte that completes while the transmit holding slot is full is dropped and sets `overrun_o`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| byte_rdy_o | output | 1 | One-cycle strobe per good received byte |
| overrun_o | output | 1 | Sticky: a byte was dropped because the transmit slot was full |
| frame_err_o | output | 1 | Sticky: a stop bit was sampled low |

## Verification
If a bit counter or tick counter in the receiver goes wrong, bytes come out shifted or corrupted. This shows as a data miscompare on `tx_o` within one frame time of the faulty frame. If the stop-bit cut in the transmitter goes wrong, the start-to-start spacing on `tx_o` changes. In the fast-stream run this shows within a few frames, as a missing spacing below ten bit times in one mode or a spacing too short in the other. If the holding slot is mishandled, `overrun_o` rises in the wrong mode or bytes go missing, and a full sweep of all 256 byte values followed by a fast burst of 48 bytes brings either case out.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;
  localparam int OSR   = 16;
  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } line_st_t;
endpackage

// File: rtl/uart_echo_tick.sv
module uart_echo_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_q == CW'(DIV - 1)) begin
      div_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_echo_rx.sv
module uart_echo_rx
  import uart_echo_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 rx_i,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ferr_o
);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  logic [1:0]           sync_q;
  logic                 rx_s, rx_d;
  line_st_t             st;
  logic [CNT_W-1:0]     cnt;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] sh;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 2'b11;
      rx_d    <= 1'b1;
      st      <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rx_i};
      rx_d    <= rx_s;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (rx_d && !rx_s) begin
            st  <= ST_START;
            cnt <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (cnt == CNT_W'(HALF - 1)) begin
              cnt <= '0;
              idx <= '0;
              st  <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (cnt == CNT_W'(OSR - 1)) begin
              cnt <= '0;
              sh  <= {rx_s, sh[DATA_BITS-1:1]};
              if (idx == IW'(DATA_BITS - 1)) st <= ST_STOP;
              else idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick_i) begin
            if (cnt == CNT_W'(OSR - 1)) begin
              cnt <= '0;
              st  <= ST_IDLE;
              if (rx_s) begin
                valid_o <= 1'b1;
                data_o  <= sh;
              end else begin
                ferr_o <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R3: a start that survives its midpoint check must enter the data phase
  a_r3_start_confirmed: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && tick_i && cnt == CNT_W'(HALF - 1) && !rx_s) |=> (st == ST_DATA));
  // R5: a good frame gives a single-cycle strobe
  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R6: a bad stop bit never produces a byte
  a_r6_no_valid_on_ferr: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && ferr_o));
endmodule

// File: rtl/uart_echo_tx.sv
module uart_echo_tx
  import uart_echo_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter bit EARLY_START = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 full_o,
  output logic                 tx_o
);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  line_st_t             st;
  logic [CNT_W-1:0]     cnt;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] sh;
  logic [DATA_BITS-1:0] hold;
  logic                 stop_done;
  logic                 stop_cut;

  assign stop_done = (cnt == CNT_W'(OSR - 1));
  assign stop_cut  = EARLY_START && (cnt >= CNT_W'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      hold   <= '0;
      full_o <= 1'b0;
      tx_o   <= 1'b1;
    end else begin
      if (load_i) begin
        hold   <= data_i;
        full_o <= 1'b1;
      end
      case (st)
        ST_IDLE: begin
          if (full_o) begin
            st     <= ST_START;
            sh     <= hold;
            full_o <= 1'b0;
            cnt    <= '0;
            tx_o   <= 1'b0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (cnt == CNT_W'(OSR - 1)) begin
              st   <= ST_DATA;
              cnt  <= '0;
              idx  <= '0;
              tx_o <= sh[0];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (cnt == CNT_W'(OSR - 1)) begin
              cnt <= '0;
              if (idx == IW'(DATA_BITS - 1)) begin
                st   <= ST_STOP;
                tx_o <= 1'b1;
              end else begin
                idx  <= idx + 1'b1;
                sh   <= sh >> 1;
                tx_o <= sh[1];
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick_i) begin
            if (full_o && (stop_done || stop_cut)) begin
              st     <= ST_START;
              sh     <= hold;
              full_o <= 1'b0;
              cnt    <= '0;
              tx_o   <= 1'b0;
            end else if (stop_done) begin
              st  <= ST_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R1/R2: line is high whenever nothing is being sent
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> tx_o);
  // R2: start bit drives the line low
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START) |-> !tx_o);
  // R7: stop bit is never cut before more than half has gone out
  a_r7_min_stop: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP && tick_i && cnt < CNT_W'(HALF)) |=> (st == ST_STOP));
  // R8: without early start the stop bit always runs its full length
  a_r8_full_stop: assert property (@(posedge clk) disable iff (rst)
    (!EARLY_START && st == ST_STOP && tick_i && cnt < CNT_W'(OSR - 1)) |=> (st == ST_STOP));
endmodule

// File: rtl/uart_echo.sv
module uart_echo #(
  parameter int DIV         = 2,
  parameter int DATA_BITS   = 8,
  parameter bit EARLY_START = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic tx_o,
  output logic byte_rdy_o,
  output logic overrun_o,
  output logic frame_err_o
);
  logic                 tick;
  logic                 rx_valid;
  logic                 rx_ferr;
  logic [DATA_BITS-1:0] rx_data;
  logic                 tx_full;
  logic                 tx_load;

  uart_echo_tick #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  uart_echo_rx #(.DATA_BITS(DATA_BITS)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .rx_i    (rx_i),
    .valid_o (rx_valid),
    .data_o  (rx_data),
    .ferr_o  (rx_ferr)
  );

  assign tx_load = rx_valid && !tx_full;

  uart_echo_tx #(.DATA_BITS(DATA_BITS), .EARLY_START(EARLY_START)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .load_i (tx_load),
    .data_i (rx_data),
    .full_o (tx_full),
    .tx_o   (tx_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_rdy_o  <= 1'b0;
      overrun_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      byte_rdy_o <= rx_valid;
      if (rx_valid && tx_full) overrun_o <= 1'b1;
      if (rx_ferr) frame_err_o <= 1'b1;
    end
  end

  // R9: a byte arriving on a full slot raises the flag next cycle
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && tx_full) |=> overrun_o);
  // R9: the overrun flag holds until reset
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);
  // R6: the framing flag holds until reset
  a_r6_ferr_sticky: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> frame_err_o);
  // R5: strobe lasts one cycle
  a_r5_rdy_pulse: assert property (@(posedge clk) disable iff (rst)
    byte_rdy_o |=> !byte_rdy_o);
endmodule

// File: tb/uart_echo_bench.sv
`timescale 1ns/1ps
module uart_echo_bench;
  localparam int BIT_CLK = 32;  // 16 ticks * DIV 2

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx  = 1'b1;
  logic [1:0] tx, rdy, ovr, fe;

  int vectors = 0;
  int miscomp = 0;
  int cyc = 0;
  int rdy_cnt [2] = '{0, 0};
  int echo_cnt[2] = '{0, 0};
  int last_edge[2] = '{-1, -1};
  int min_iv0 = 1000000;
  bit fast = 1'b0;
  logic [7:0] sent [0:511];
  int n_sent = 0;

  always #2.5 clk = ~clk;

  uart_echo #(.DIV(2), .DATA_BITS(8), .EARLY_START(1'b1)) u_uart_echo (
    .clk(clk), .rst(rst), .rx_i(rx), .tx_o(tx[0]),
    .byte_rdy_o(rdy[0]), .overrun_o(ovr[0]), .frame_err_o(fe[0]));

  uart_echo #(.DIV(2), .DATA_BITS(8), .EARLY_START(1'b0)) u_uart_echo_safe (
    .clk(clk), .rst(rst), .rx_i(rx), .tx_o(tx[1]),
    .byte_rdy_o(rdy[1]), .overrun_o(ovr[1]), .frame_err_o(fe[1]));

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst) begin
      if (rdy[0] === 1'b1) rdy_cnt[0] <= rdy_cnt[0] + 1;
      if (rdy[1] === 1'b1) rdy_cnt[1] <= rdy_cnt[1] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  endtask

  task automatic send(input logic [7:0] b, input int bclk, input logic stop_v);
    rx = 1'b0;
    repeat (bclk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (bclk) @(negedge clk);
    end
    rx = stop_v;
    repeat (bclk) @(negedge clk);
  endtask

  task automatic dec(input int k);
    int t0;
    int iv;
    logic [7:0] b;
    t0 = cyc;
    repeat (BIT_CLK / 2) @(negedge clk);
    chk(tx[k] === 1'b0, "R2 start bit low", int'(tx[k]), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT_CLK) @(negedge clk);
      b[i] = tx[k];
    end
    repeat (BIT_CLK) @(negedge clk);
    chk(tx[k] === 1'b1, "R2 stop bit high", int'(tx[k]), 1);
    if (!(k == 1 && fast))
      chk(b === sent[echo_cnt[k]], "R2 echo data", int'(b), int'(sent[echo_cnt[k]]));
    if (last_edge[k] >= 0) begin
      iv = t0 - last_edge[k];
      if (k == 1) chk(iv >= 10 * BIT_CLK, "R8 full frame spacing", iv, 10 * BIT_CLK);
      if (k == 0 && fast && iv < min_iv0) min_iv0 = iv;
    end
    last_edge[k] = t0;
    echo_cnt[k]++;
  endtask

  always begin @(negedge tx[0]); dec(0); end
  always begin @(negedge tx[1]); dec(1); end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int base;
    int rbase;
    int eb0, eb1;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(tx[k] === 1'b1, "R1 tx idle high", int'(tx[k]), 1);
      chk(rdy[k] === 1'b0, "R1 strobe low", int'(rdy[k]), 0);
      chk(ovr[k] === 1'b0, "R1 overrun low", int'(ovr[k]), 0);
      chk(fe[k] === 1'b0, "R1 frame error low", int'(fe[k]), 0);
    end
    repeat (100) @(negedge clk);

    // R2/R5: every byte value, nominal rate, back to back
    for (int b = 0; b < 256; b++) begin
      sent[n_sent] = 8'(b);
      n_sent++;
      send(8'(b), BIT_CLK, 1'b1);
    end
    repeat (700) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(echo_cnt[k] == 256, "R2 echo count", echo_cnt[k], 256);
      chk(rdy_cnt[k] == 256, "R5 strobe count", rdy_cnt[k], 256);
      chk(ovr[k] === 1'b0, "R9 no overrun at nominal", int'(ovr[k]), 0);
    end

    // R3: short low glitch is rejected
    rbase = rdy_cnt[0];
    eb0 = echo_cnt[0];
    rx = 1'b0;
    repeat (8) @(negedge clk);
    rx = 1'b1;
    repeat (400) @(negedge clk);
    chk(rdy_cnt[0] == rbase, "R3 glitch gives no strobe", rdy_cnt[0], rbase);
    chk(echo_cnt[0] == eb0, "R3 glitch gives no echo", echo_cnt[0], eb0);
    chk(tx[0] === 1'b1, "R3 line stays idle", int'(tx[0]), 1);
    chk(fe[0] === 1'b0, "R3 no frame error", int'(fe[0]), 0);

    // R6: low stop bit
    rbase = rdy_cnt[1];
    eb1 = echo_cnt[1];
    send(8'h5A, BIT_CLK, 1'b0);
    rx = 1'b1;
    repeat (700) @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(fe[k] === 1'b1, "R6 frame error set", int'(fe[k]), 1);
    chk(rdy_cnt[1] == rbase, "R6 no strobe on bad frame", rdy_cnt[1], rbase);
    chk(echo_cnt[1] == eb1, "R6 no echo on bad frame", echo_cnt[1], eb1);
    sent[n_sent] = 8'hC3;
    n_sent++;
    send(8'hC3, BIT_CLK, 1'b1);
    repeat (700) @(negedge clk);
    chk(echo_cnt[1] == eb1 + 1, "R6 recovery echo", echo_cnt[1], eb1 + 1);
    chk(fe[1] === 1'b1, "R6 flag stays set", int'(fe[1]), 1);

    // R4/R7/R8/R9: stream about 3% fast
    fast = 1'b1;
    base = n_sent;
    rbase = rdy_cnt[0];
    for (int i = 0; i < 48; i++) begin
      v = 8'((i * 37 + 11) & 255);
      sent[n_sent] = v;
      n_sent++;
      send(v, BIT_CLK - 1, 1'b1);
    end
    repeat (1500) @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(rdy_cnt[k] == rbase + 48, "R4 fast stream fully received", rdy_cnt[k], rbase + 48);
    chk(echo_cnt[0] == base + 48, "R7 all fast bytes echoed", echo_cnt[0], base + 48);
    chk(ovr[0] === 1'b0, "R7 no overrun with early start", int'(ovr[0]), 0);
    chk(min_iv0 < 10 * BIT_CLK, "R7 stop bit trimmed", min_iv0, 10 * BIT_CLK - 1);
    chk(ovr[1] === 1'b1, "R9 overrun with full frames", int'(ovr[1]), 1);
    chk(echo_cnt[1] < base + 48, "R9 bytes dropped", echo_cnt[1], base + 47);
    finish_run();
  end
endmodule